// File: doc/BRIEF.md
# Legacy DMA Controller Register Port Front End

This block is the byte-wide register front end of a four-channel DMA controller. It holds each channel's 16-bit address and 16-bit word count registers. Software reaches them through one 8-bit data path. A byte pointer flip-flop selects the low or high half of a 16-bit register. The pointer is shared by every 16-bit register and flips after each access to any of them. The block also holds an 8-bit command register, a 4-bit request register, a 4-bit mask register and a status view built from the request bits.

Three write-only command ports act on groups of state, and the data written to them is ignored:
- the pointer reset port clears the byte pointer;
- the full reset port behaves like a hardware reset of the control state;
- the unmask port clears every channel mask bit.

A parameter selects the low-bank or the high-bank instance. The low bank decodes register index i at address i. The high bank decodes index i at address C0h + 2i, so only even addresses respond. Transfer sequencing, arbitration and cascading live elsewhere.

Register index map (the same for both banks):

| Index | Access | Register |
|---|---|---|
| 0..7 | read/write | Channel n address at index 2n, channel n word count at index 2n+1 |
| 8 | read | Status |
| 9 | read/write | Request |
| 10 | write | Single mask |
| 11 | read/write | Command |
| 12 | write | Pointer reset |
| 13 | write | Full reset |
| 14 | write | Unmask |
| 15 | read/write | Mask, all bits |

Top module: `dmac_cmd_regs`

## Requirements
- R1: A write to the pointer reset port (index 12) clears the byte pointer whatever data is written, so the next 16-bit access reaches the low byte.
- R2: With the pointer clear, the first access to a channel register (index 0..7) reaches bits 7:0 and the next reaches bits 15:8. The pointer flips after every channel register read or write, and one pointer is shared by all channel registers.
- R3: Hardware reset and the full reset port (index 13) both clear the byte pointer. The full reset port leaves channel address and word count contents unchanged.
- R4: A write to the full reset port clears the command and request registers, and so the status, and sets all four mask bits. Hardware reset produces the same state.
- R5: A write to the unmask port (index 14) clears all four mask bits whatever data is written.
- R6: The low bank decodes index i at address i for i in 0..15. The high bank decodes index i at address C0h+2i, so its command ports are at D8h, DAh and DCh. Each bank ignores the other bank's addresses.
- R7: Reads of indices 10, 12, 13 and 14, and of any address the bank does not decode, return 00h.
- R8: Request write (index 9) and single mask write (index 10) use data[1:0] as the channel and data[2] as set (1) or clear (0). Request reads as {4'b0, req}. Status (index 8) reads as {req, 4'b0}. Mask all (index 15) writes mask from data[3:0] and reads as {4'b0, mask}. Command (index 11) reads back the last value written.
- R9: Read data is registered: io_rdata takes the addressed value on the clock edge where io_rd is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |

## Verification
The byte pointer is exercised in several ways:
- a plain low-then-high write and readback on one register;
- a split access in which the low byte goes to one register and the next byte lands in the high half of a different register, which shows that the pointer is shared;
- a pointer reset in the middle of a pair with a nonzero data value, which shows that the data is ignored;
- the pointer state after each clear source.

Full reset is applied with the command, request, mask and pointer all in non-reset states, and a channel register is read afterwards to show that its contents are kept. A low-bank and a high-bank instance share one bus. This shows that each bank answers only its own addresses and that a command written to one bank leaves the other bank's pointer and mask unchanged.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;
    localparam int NUM_CH  = 4;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = 4;
    localparam logic [ADDR_W-1:0] HIGH_BASE = 8'hC0;

    localparam logic [IDX_W-1:0] IX_STATUS = 4'd8;
    localparam logic [IDX_W-1:0] IX_REQ    = 4'd9;
    localparam logic [IDX_W-1:0] IX_SMASK  = 4'd10;
    localparam logic [IDX_W-1:0] IX_CMD    = 4'd11;
    localparam logic [IDX_W-1:0] IX_PCLR   = 4'd12;
    localparam logic [IDX_W-1:0] IX_FRST   = 4'd13;
    localparam logic [IDX_W-1:0] IX_UNMASK = 4'd14;
    localparam logic [IDX_W-1:0] IX_AMASK  = 4'd15;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } port_sel_t;

    typedef struct packed {
        logic chan_wr;
        logic chan_rd;
        logic req_wr;
        logic smask_wr;
        logic cmd_wr;
        logic amask_wr;
        logic ptr_clr;
        logic full_rst;
        logic unmask;
    } strobes_t;

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic [NUM_CH-1:0] req;
        logic [NUM_CH-1:0] mask;
    } ctrl_t;

    function automatic port_sel_t decode_port(input logic [ADDR_W-1:0] a,
                                              input logic high);
        port_sel_t s;
        logic [ADDR_W-1:0] off;
        off = a - HIGH_BASE;
        if (high) begin
            s.hit = (a >= HIGH_BASE) && (off < 8'd32) && !a[0];
            s.idx = off[IDX_W:1];
        end else begin
            s.hit = (a < 8'd16);
            s.idx = a[IDX_W-1:0];
        end
        return s;
    endfunction
endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
    import dmac_regs_pkg::*;
#(
    parameter bit HIGH_BANK = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output port_sel_t         sel,
    output strobes_t          st
);
    always_comb begin
        sel        = decode_port(addr, HIGH_BANK);
        st         = '0;
        st.chan_wr = wr && sel.hit && !sel.idx[IDX_W-1];
        st.chan_rd = rd && sel.hit && !sel.idx[IDX_W-1];
        if (wr && sel.hit) begin
            st.req_wr   = (sel.idx == IX_REQ);
            st.smask_wr = (sel.idx == IX_SMASK);
            st.cmd_wr   = (sel.idx == IX_CMD);
            st.ptr_clr  = (sel.idx == IX_PCLR);
            st.full_rst = (sel.idx == IX_FRST);
            st.unmask   = (sel.idx == IX_UNMASK);
            st.amask_wr = (sel.idx == IX_AMASK);
        end
    end
endmodule

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic access,
    input  logic clear,
    output logic hi_sel
);
    always_ff @(posedge clk) begin
        if (rst || clear) hi_sel <= 1'b0;
        else if (access)  hi_sel <= ~hi_sel;
    end

    assert_ptr_flip_R2: assert property (@(posedge clk) disable iff (rst)
        (access && !clear) |=> (hi_sel != $past(hi_sel)));
    assert_ptr_clear_R1: assert property (@(posedge clk) disable iff (rst)
        clear |=> !hi_sel);
    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!access && !clear) |=> $stable(hi_sel));
endmodule

// File: rtl/dmac_chan_file.sv
module dmac_chan_file
    import dmac_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   chan,
    input  logic              is_count,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [2*DATA_W-1:0] rd_word
);
    logic [2*DATA_W-1:0] addr_q  [NUM_CH];
    logic [2*DATA_W-1:0] count_q [NUM_CH];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic hit;
        assign hit = wr_en && (chan == n[CH_W-1:0]);
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[n]  <= '0;
                count_q[n] <= '0;
            end else if (hit) begin
                if (is_count) begin
                    if (hi_sel) count_q[n][2*DATA_W-1:DATA_W] <= wdata;
                    else        count_q[n][DATA_W-1:0]        <= wdata;
                end else begin
                    if (hi_sel) addr_q[n][2*DATA_W-1:DATA_W]  <= wdata;
                    else        addr_q[n][DATA_W-1:0]         <= wdata;
                end
            end
        end
    end

    assign rd_word = is_count ? count_q[chan] : addr_q[chan];
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  strobes_t          st,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);
    logic [NUM_CH-1:0] one_hot;
    assign one_hot = NUM_CH'(1) << wdata[CH_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || st.full_rst) begin
            ctrl.cmd  <= '0;
            ctrl.req  <= '0;
            ctrl.mask <= '1;
        end else begin
            if (st.cmd_wr) ctrl.cmd <= wdata;
            if (st.req_wr) begin
                if (wdata[2]) ctrl.req <= ctrl.req | one_hot;
                else          ctrl.req <= ctrl.req & ~one_hot;
            end
            if (st.unmask)        ctrl.mask <= '0;
            else if (st.amask_wr) ctrl.mask <= wdata[NUM_CH-1:0];
            else if (st.smask_wr) begin
                if (wdata[2]) ctrl.mask <= ctrl.mask | one_hot;
                else          ctrl.mask <= ctrl.mask & ~one_hot;
            end
        end
    end

    assert_full_rst_R4: assert property (@(posedge clk) disable iff (rst)
        st.full_rst |=> (ctrl.mask == '1 && ctrl.cmd == '0 && ctrl.req == '0));
    assert_unmask_R5: assert property (@(posedge clk) disable iff (rst)
        st.unmask |=> (ctrl.mask == '0));
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st.req_wr, st.smask_wr, st.cmd_wr, st.amask_wr,
                  st.ptr_clr, st.full_rst, st.unmask, st.chan_wr}));
endmodule

// File: rtl/dmac_cmd_regs.sv
module dmac_cmd_regs
    import dmac_regs_pkg::*;
#(
    parameter bit HIGH_BANK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata
);
    port_sel_t           sel;
    strobes_t            st;
    ctrl_t               ctrl;
    logic                hi_sel;
    logic [2*DATA_W-1:0] word;
    logic [DATA_W-1:0]   rd_val;

    dmac_port_decode #(.HIGH_BANK(HIGH_BANK)) u_dec (
        .addr(io_addr), .wr(io_wr), .rd(io_rd), .sel(sel), .st(st));

    dmac_byte_ptr u_ptr (
        .clk(clk), .rst(rst),
        .access(st.chan_wr || st.chan_rd),
        .clear(st.ptr_clr || st.full_rst),
        .hi_sel(hi_sel));

    dmac_chan_file u_chan (
        .clk(clk), .rst(rst), .wr_en(st.chan_wr),
        .chan(sel.idx[CH_W:1]), .is_count(sel.idx[0]),
        .hi_sel(hi_sel), .wdata(io_wdata), .rd_word(word));

    dmac_ctrl_regs u_ctrl (
        .clk(clk), .rst(rst), .st(st), .wdata(io_wdata), .ctrl(ctrl));

    always_comb begin
        rd_val = '0;
        if (sel.hit) begin
            if (!sel.idx[IDX_W-1]) begin
                rd_val = hi_sel ? word[2*DATA_W-1:DATA_W] : word[DATA_W-1:0];
            end else begin
                case (sel.idx)
                    IX_STATUS: rd_val = {ctrl.req, 4'b0000};
                    IX_REQ:    rd_val = {4'b0000, ctrl.req};
                    IX_CMD:    rd_val = ctrl.cmd;
                    IX_AMASK:  rd_val = {4'b0000, ctrl.mask};
                    default:   rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        io_rdata <= '0;
        else if (io_rd) io_rdata <= rd_val;
    end

    assert_wo_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (io_rd && (!sel.hit || sel.idx == IX_PCLR || sel.idx == IX_FRST ||
                   sel.idx == IX_UNMASK || sel.idx == IX_SMASK))
        |=> (io_rdata == '0));
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/sim_dmac_cmd_regs.sv
module sim_dmac_cmd_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] rdata_lo, rdata_hi;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmac_cmd_regs #(.HIGH_BANK(1'b0)) u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_lo));
    dmac_cmd_regs #(.HIGH_BANK(1'b1)) u1 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_hi));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_lo(input logic [7:0] a, input string req, input logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check(req, rdata_lo, exp);
    endtask

    task automatic rd_hi(input logic [7:0] a, input string req, input logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check(req, rdata_hi, exp);
    endtask

    task automatic t_reset_state;
        rd_lo(8'h0F, "R4 reset mask", 8'h0F);
        rd_lo(8'h0B, "R4 reset cmd", 8'h00);
        rd_lo(8'h08, "R4 reset status", 8'h00);
        rd_lo(8'h00, "R3 reset ptr low", 8'h00);
        rd_lo(8'h00, "R3 reset ptr high", 8'h00);
        rd_hi(8'hDE, "R6 high bank reset mask", 8'h0F);
    endtask

    task automatic t_pointer;
        wr(8'h02, 8'h34); wr(8'h02, 8'h12);
        rd_lo(8'h02, "R2 ch1 addr low", 8'h34);
        rd_lo(8'h02, "R2 ch1 addr high", 8'h12);
        wr(8'h0C, 8'hA5);
        wr(8'h04, 8'h56);
        wr(8'h05, 8'h78);
        wr(8'h0C, 8'h00);
        rd_lo(8'h05, "R2 shared ptr count low", 8'h00);
        rd_lo(8'h05, "R2 shared ptr count high", 8'h78);
        rd_lo(8'h04, "R2 shared ptr addr low", 8'h56);
        rd_lo(8'h04, "R2 shared ptr addr high", 8'h00);
        wr(8'h06, 8'hEE);
        wr(8'h0C, 8'hFF);
        wr(8'h06, 8'hEF);
        wr(8'h06, 8'h01);
        rd_lo(8'h06, "R1 clear mid pair low", 8'hEF);
        rd_lo(8'h06, "R1 clear mid pair high", 8'h01);
    endtask

    task automatic t_full_reset;
        wr(8'h0B, 8'h5A);
        rd_lo(8'h0B, "R8 cmd readback", 8'h5A);
        wr(8'h09, 8'h05);
        wr(8'h0F, 8'h00);
        rd_lo(8'h08, "R8 status from request", 8'h20);
        rd_lo(8'h09, "R8 request read", 8'h02);
        wr(8'h00, 8'h77);
        wr(8'h0D, 8'hC3);
        rd_lo(8'h0F, "R4 full reset mask", 8'h0F);
        rd_lo(8'h0B, "R4 full reset cmd", 8'h00);
        rd_lo(8'h08, "R4 full reset status", 8'h00);
        rd_lo(8'h09, "R4 full reset request", 8'h00);
        rd_lo(8'h02, "R3 ptr cleared, ch1 low kept", 8'h34);
        rd_lo(8'h02, "R3 ch1 high kept", 8'h12);
        rd_lo(8'h00, "R3 ch0 low kept", 8'h77);
        rd_lo(8'h00, "R3 ch0 high", 8'h00);
    endtask

    task automatic t_masks;
        wr(8'h0E, 8'hFF);
        rd_lo(8'h0F, "R5 unmask", 8'h00);
        wr(8'h0A, 8'h06);
        rd_lo(8'h0F, "R8 single mask set ch2", 8'h04);
        wr(8'h0A, 8'h02);
        rd_lo(8'h0F, "R8 single mask clear ch2", 8'h00);
        wr(8'h0F, 8'h09);
        rd_lo(8'h0F, "R8 mask all write", 8'h09);
        wr(8'h0E, 8'h00);
        rd_lo(8'h0F, "R5 unmask zero data", 8'h00);
    endtask

    task automatic t_wo_reads;
        rd_lo(8'h0C, "R7 pointer reset port reads zero", 8'h00);
        rd_lo(8'h0D, "R7 full reset port reads zero", 8'h00);
        rd_lo(8'h0E, "R7 unmask port reads zero", 8'h00);
        rd_lo(8'h0A, "R7 single mask port reads zero", 8'h00);
        rd_lo(8'h40, "R7 undecoded low bank", 8'h00);
        rd_hi(8'hD9, "R7 odd high bank address", 8'h00);
    endtask

    task automatic t_high_bank;
        wr(8'hC0, 8'h11);
        wr(8'h0C, 8'h00);
        wr(8'hC0, 8'h22);
        wr(8'hD8, 8'h5A);
        rd_hi(8'hC0, "R6 high ch0 low", 8'h11);
        rd_hi(8'hC0, "R6 high ch0 high, low-bank clear ignored", 8'h22);
        wr(8'hDC, 8'h00);
        rd_hi(8'hDE, "R6 high unmask at DC", 8'h00);
        wr(8'h0F, 8'h03);
        wr(8'hDA, 8'h00);
        rd_hi(8'hDE, "R6 high full reset at DA", 8'h0F);
        rd_lo(8'h0F, "R6 low mask untouched by high ports", 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_pointer();
        t_full_reset();
        t_masks();
        t_wo_reads();
        t_high_bank();
        rd_lo(8'h08, "R9 read value", 8'h00);
        repeat (3) @(negedge clk);
        check("R9 read data held", rdata_lo, 8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule